// File: doc/BRIEF.md
# Unsigned Long Multiply-Accumulate Unit

This execution unit multiplies two unsigned 32-bit operands into a full 64-bit product. It can then fold accumulator values into that product and return the result as a high word and a low word. A 2-bit operation code picks the operation. Plain long multiply ignores the accumulator inputs. Wide accumulate treats the two accumulator inputs as one 64-bit value, with the high input as the upper half. Dual accumulate adds each accumulator input to the product as its own zero-extended 32-bit addend. The unit keeps no condition flags.

A request is taken on a clock edge where `start` and `ready` are both high. The operands, the accumulators, the operation code and two destination tags are captured on that edge. The product comes from a radix-2 shift-add datapath that examines one multiplier bit per cycle. One further cycle applies the accumulate step and one more registers the result. A request is rejected if its operation code is reserved or if its two destination tags are equal. A rejected request skips the datapath and returns zero with `err` set.

The controller has five states:
- IDLE: ready, waiting for a request.
- MUL: one shift-add step per cycle for 32 cycles.
- ACC: the accumulate step.
- REJECT: a one-cycle stand-in for a rejected request.
- FINISH: writes the result and pulses `done`.

The transitions are:
- accept-legal: IDLE to MUL.
- accept-reject: IDLE to REJECT.
- last-step: MUL to ACC, after the 32nd step.
- sum-ready: ACC to FINISH.
- reject-report: REJECT to FINISH.
- retire: FINISH to IDLE.

Top module: `umac_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the unit goes idle. After that edge, `ready`=1, `done`=0, `err`=0, `res_hi`=0 and `res_lo`=0.
- R2: Operation code 2'b00 (plain multiply) returns product bits 31:0 on `res_lo` and bits 63:32 on `res_hi`. The values on `acc_hi` and `acc_lo` have no effect on the result.
- R3: Operation code 2'b01 (wide accumulate) returns the product plus {`acc_hi`,`acc_lo`}, truncated to 64 bits. The upper 32 bits go to `res_hi` and the lower 32 bits to `res_lo`.
- R4: Operation code 2'b10 (dual accumulate) returns the product plus zero-extended `acc_hi` plus zero-extended `acc_lo`. This sum never exceeds 2^64-1.
- R5: For a legal request, `done` is high in the cycle that follows the clock edge 34 edges after the accept edge.
- R6: Operation code 2'b11 is reserved. Such a request returns zero on both result words and sets `err`=1 with `done`, two edges after the accept edge.
- R7: A request whose `tag_hi` equals `tag_lo` is not executed. It returns zero with `err`=1 and `done` two edges after the accept edge, whatever its operation code.
- R8: `ready` is low from the edge after an accept until the result is retired. A `start` pulse in that window is ignored: it neither changes the running result nor produces an extra `done`.
- R9: `done` lasts exactly one cycle. `res_hi`, `res_lo` and `err` change only in a cycle where `done` is high, and otherwise hold their values.
- R10: A legal request completes with `err`=0. A new request may be accepted in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| ready | output | 1 | Unit idle and able to accept |
| op | input | 2 | Operation code (00 mul, 01 wide acc, 10 dual acc, 11 reserved) |
| tag_hi | input | 4 | Destination tag of the high result word |
| tag_lo | input | 4 | Destination tag of the low result word |
| opnd_a | input | 32 | First unsigned operand |
| opnd_b | input | 32 | Second unsigned operand |
| acc_hi | input | 32 | High accumulator input |
| acc_lo | input | 32 | Low accumulator input |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request was rejected |

## Verification
The assertions check the following on every cycle:
- the single-cycle `done` pulse;
- that results hold between completions;
- that `ready` drops after an accept;
- that ACC is entered only from the last shift-add step;
- that a rejected result is zero;
- that dual accumulate never carries out of 64 bits;
- that equal tags route to the reject state.

The arithmetic values in the three operation modes can only be shown by the bench's scenarios. The same holds for the exact 34-cycle and 2-cycle latencies, for accumulator inputs being ignored by plain multiply, for wrap in wide accumulate, and for back-to-back issue in the `done` cycle. The bench compares each of these against values it computes itself.

// File: rtl/umac_pkg.sv
package umac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_ACC,
        ST_REJECT,
        ST_FINISH
    } umac_state_e;

    typedef enum logic [1:0] {
        OP_MUL   = 2'b00,
        OP_ACC64 = 2'b01,
        OP_DUAL  = 2'b10,
        OP_RSVD  = 2'b11
    } umac_op_e;

endpackage

// File: rtl/umac_ctrl.sv
module umac_ctrl
    import umac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        legal,
    output umac_state_e state,
    output logic        ready,
    output logic        load,
    output logic        step,
    output logic        sum_en,
    output logic        finish
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    umac_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = legal ? ST_MUL : ST_REJECT;
            ST_MUL:    if (cnt_q == LAST) state_d = ST_ACC;
            ST_ACC:    state_d = ST_FINISH;
            ST_REJECT: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready  = (state_q == ST_IDLE);
        load   = ready && start;
        step   = (state_q == ST_MUL);
        sum_en = (state_q == ST_ACC);
        finish = (state_q == ST_FINISH);
    end

    assign state = state_q;

    AST_ACC_AFTER_LAST_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACC) |-> ($past(state_q) == ST_MUL && $past(cnt_q) == LAST)); // R5

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready); // R8

endmodule

// File: rtl/umac_shift_mul.sv
module umac_shift_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] acc_q;
    logic [PW-1:0] addend;

    assign addend = mplier_q[0] ? mcand_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= {{W{1'b0}}, a};
            mplier_q <= b;
            acc_q    <= '0;
        end else if (step) begin
            acc_q    <= acc_q + addend;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign prod = acc_q;

endmodule

// File: rtl/umac_accum.sv
module umac_accum
    import umac_pkg::*;
#(
    parameter int W = 32
) (
    input  umac_op_e       op,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   acc_hi,
    input  logic [W-1:0]   acc_lo,
    output logic [2*W-1:0] sum,
    output logic           carry
);
    localparam int SW = 2 * W + 1;

    logic [SW-1:0] wide;

    always_comb begin
        wide = '0;
        unique case (op)
            OP_MUL:   wide = {1'b0, prod};
            OP_ACC64: wide = {1'b0, prod} + {1'b0, acc_hi, acc_lo};
            OP_DUAL:  wide = {1'b0, prod} + SW'(acc_hi) + SW'(acc_lo);
            OP_RSVD:  wide = '0;
            default:  wide = '0;
        endcase
    end

    assign sum   = wide[SW-2:0];
    assign carry = wide[SW-1];

endmodule

// File: rtl/umac_unit.sv
module umac_unit
    import umac_pkg::*;
#(
    parameter int W  = 32,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          ready,
    input  logic [1:0]    op,
    input  logic [TW-1:0] tag_hi,
    input  logic [TW-1:0] tag_lo,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [W-1:0]  acc_hi,
    input  logic [W-1:0]  acc_lo,
    output logic [W-1:0]  res_hi,
    output logic [W-1:0]  res_lo,
    output logic          done,
    output logic          err
);
    localparam int PW = 2 * W;

    umac_state_e   state;
    logic          load, step, sum_en, finish, legal, carry;
    umac_op_e      op_q;
    logic [W-1:0]  acc_hi_q, acc_lo_q;
    logic          rej_q;
    logic [PW-1:0] prod, sum_now, sum_q;

    assign legal = (umac_op_e'(op) != OP_RSVD) && (tag_hi != tag_lo);

    umac_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .legal(legal),
        .state(state), .ready(ready), .load(load), .step(step),
        .sum_en(sum_en), .finish(finish)
    );

    umac_shift_mul #(.W(W)) u_mul (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .a(opnd_a), .b(opnd_b), .prod(prod)
    );

    umac_accum #(.W(W)) u_acc (
        .op(op_q), .prod(prod), .acc_hi(acc_hi_q), .acc_lo(acc_lo_q),
        .sum(sum_now), .carry(carry)
    );

    // request capture and accumulate stage
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_MUL;
            acc_hi_q <= '0;
            acc_lo_q <= '0;
            rej_q    <= 1'b0;
            sum_q    <= '0;
        end else begin
            if (load) begin
                op_q     <= umac_op_e'(op);
                acc_hi_q <= acc_hi;
                acc_lo_q <= acc_lo;
                rej_q    <= !legal;
            end
            if (sum_en)
                sum_q <= sum_now;
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_hi <= '0;
            res_lo <= '0;
            err    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                res_hi <= rej_q ? '0 : sum_q[PW-1:W];
                res_lo <= rej_q ? '0 : sum_q[W-1:0];
                err    <= rej_q;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_hi) && $stable(res_lo) && $stable(err))); // R9

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (res_hi == '0 && res_lo == '0)); // R6

    AST_DUAL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACC && op_q == OP_DUAL) |-> !carry); // R4

    AST_TAG_CLASH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (start && ready && tag_hi == tag_lo) |=> (state == ST_REJECT)); // R7

endmodule

// File: tb/umac_unit_bench.sv
`timescale 1ns/1ps
module umac_unit_bench;
    localparam int W  = 32;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          ready;
    logic [1:0]    op = 2'b00;
    logic [TW-1:0] tag_hi = 4'd1, tag_lo = 4'd0;
    logic [W-1:0]  opnd_a = '0, opnd_b = '0, acc_hi = '0, acc_lo = '0;
    logic [W-1:0]  res_hi, res_lo;
    logic          done, err;

    always #2.5 clk = ~clk;

    umac_unit #(.W(W), .TW(TW)) u_umac_unit (
        .clk(clk), .rst(rst), .start(start), .ready(ready), .op(op),
        .tag_hi(tag_hi), .tag_lo(tag_lo), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .res_hi(res_hi), .res_lo(res_lo),
        .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [63:0] exp_val_q[$];
    logic        exp_err_q[$];
    int          exp_due_q[$];
    string       exp_req_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: issues one request and pushes the expected outcome
    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] h, input logic [31:0] l,
                         input logic [3:0] th, input logic [3:0] tl, input string req);
        logic [63:0] p, e;
        bit lg;
        @(negedge clk);
        while (!ready) @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; acc_hi = h; acc_lo = l;
        tag_hi = th; tag_lo = tl; start = 1'b1;
        p  = {32'b0, a} * {32'b0, b};
        lg = (o != 2'b11) && (th != tl);
        case (o)
            2'b00:   e = p;
            2'b01:   e = p + {h, l};
            2'b10:   e = p + {32'b0, h} + {32'b0, l};
            default: e = '0;
        endcase
        if (!lg) e = '0;
        exp_val_q.push_back(e);
        exp_err_q.push_back(!lg);
        exp_due_q.push_back(cyc + 1 + (lg ? 34 : 2));
        exp_req_q.push_back(req);
        @(negedge clk);
        start = 1'b0;
        opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1234_5678; acc_hi = '1; acc_lo = '1;
    endtask

    // monitor: compares each completion with the scoreboard head
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_val_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", 64'd1, 64'd0);
            end else begin
                logic [63:0] ev;
                logic        ee;
                int          ed;
                string       er;
                ev = exp_val_q.pop_front();
                ee = exp_err_q.pop_front();
                ed = exp_due_q.pop_front();
                er = exp_req_q.pop_front();
                check({res_hi, res_lo} == ev, {er, " value"}, {res_hi, res_lo}, ev);
                check(err == ee, {er, " err"}, 64'(err), 64'(ee));
                check(cyc == ed, {er, " cycle"}, 64'(cyc), 64'(ed));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drain();
        while (exp_val_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
        check(done == 1'b0, "R1 done", 64'(done), 64'd0);
        check(err == 1'b0, "R1 err", 64'(err), 64'd0);
        check({res_hi, res_lo} == 64'd0, "R1 result", {res_hi, res_lo}, 64'd0);

        issue(2'b00, 32'd7, 32'd9, 32'hFFFF_FFFF, 32'h1234, 4'd1, 4'd2, "R2 R5 R10 small");
        issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5, 32'h6, 4'd3, 4'd4, "R2 R5 max");
        issue(2'b00, 32'h0, 32'hABCD_0123, 32'h0, 32'h0, 4'd0, 4'd1, "R2 zero");
        issue(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1, 32'hFFFF_FFFF, 4'd2, 4'd5, "R3 R5 carry");
        issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd6, 4'd7, "R3 wrap");
        issue(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd8, 4'd9, "R4 R5 max");
        issue(2'b10, 32'h0001_0000, 32'h0003_0000, 32'h8000_0000, 32'h8000_0001, 4'd1, 4'd0, "R4 mixed");
        issue(2'b11, 32'd5, 32'd5, 32'd1, 32'd1, 4'd1, 4'd2, "R6 reserved");
        issue(2'b00, 32'd5, 32'd5, 32'd1, 32'd1, 4'd3, 4'd3, "R7 tag clash");
        issue(2'b01, 32'd2, 32'd3, 32'd0, 32'd4, 4'd9, 4'd9, "R7 tag clash acc");
        drain();

        // start pulses while busy are ignored
        issue(2'b01, 32'h0000_1000, 32'h0000_2000, 32'hA, 32'hB, 4'd1, 4'd2, "R8 busy run");
        for (int i = 0; i < 3; i++) begin
            op = 2'b00; opnd_a = 32'd1; opnd_b = 32'd1; tag_hi = 4'd1; tag_lo = 4'd2;
            start = 1'b1;
            check(ready == 1'b0, "R8 ready low", 64'(ready), 64'd0);
            @(negedge clk);
        end
        start = 1'b0;
        drain();

        // results hold between completions
        held = {res_hi, res_lo};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check({res_hi, res_lo} == held && !done, "R9 hold", {res_hi, res_lo}, held);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule